// File: doc/BRIEF.md
# Microstepping Step/Direction Indexer

This block converts a step pulse and a direction level into a position on a 32-point electrical cycle of a two-phase stepper motor. Each position is 11.25 degrees from its neighbours. For each of the two windings the block outputs a current setpoint as a percentage of full scale, together with a polarity bit. Winding A follows the cosine of the electrical angle and winding B follows the sine. The setpoints feed external current-regulation hardware, which is not part of this block.

A 2-bit mode input sets how far one step pulse moves the position. The choices are full, half, quarter or eighth stepping. The step input is asynchronous to the block clock, so it passes through a two-flop synchroniser. Only its rising edges count. The position starts at the 45-degree home point, where both windings sit at +71 percent. An active-low flag reports when the position is at home. A park input holds the position at home. So does a one-cycle return-home request from a fault manager. A sleep input freezes the position. A registered bridge-enable output combines the park, enable and sleep qualifiers.

Top module: `stepidx_top`

## Requirements
- R1: The step size per accepted step edge depends on `mode`: 2'b00 moves 8 positions (full), 2'b01 moves 4 (half), 2'b10 moves 2 (quarter) and 2'b11 moves 1 (eighth).
- R2: With `dir_fwd` high the position index increases. With it low the index decreases. Both directions wrap modulo 32.
- R3: For index k (angle 11.25·k degrees), `a_mag`/`a_neg` encode cos and `b_mag`/`b_neg` encode sin. Magnitudes are percentages from the set 100, 98, 92, 83, 71, 56, 38, 20, 0. A polarity bit of 1 means negative. A zero magnitude always carries polarity 0.
- R4: After the system reset `rst_n`, the index is home (k = 4). Both windings are then at +71.
- R5: `home_n` is 0 exactly when the index equals home. It is 1 at every other index.
- R6: While `park_n` is low, the index is forced to home and step edges are ignored. `bridge_on` is 0 from the next clock edge.
- R7: While `enable` is low, step edges still move the index. `bridge_on` is 0 from the next clock edge.
- R8: While `sleep_n` is low, step edges are ignored and the index holds. `bridge_on` is 0 from the next clock edge. A step edge that arrives entirely during sleep has no effect after wake.
- R9: A one-cycle `fault_home` pulse forces the index to home on the following clock edge.
- R10: A rising edge of `step` moves the index on the third rising clock edge after it. This latency is two synchroniser flops plus the index register. Each rising edge causes exactly one move, however long `step` stays high.
- R11: `dir_fwd` and `mode` are taken at the clock edge that applies the move. A mode change does not realign the index: from index 19, a full step forward gives 27.
- R12: `bridge_on` is 1 one clock edge after `park_n`, `enable` and `sleep_n` are all high. It is 0 during system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| step | input | 1 | Asynchronous step command; its rising edges count |
| dir_fwd | input | 1 | 1 = forward, 0 = reverse |
| mode | input | 2 | Step size select (see R1) |
| park_n | input | 1 | Active-low hold-at-home and bridge disable |
| fault_home | input | 1 | Return-home request from the fault manager |
| sleep_n | input | 1 | Active-low sleep; freezes the position |
| enable | input | 1 | Bridge output enable qualifier |
| a_mag | output | 7 | Winding A magnitude, percent of full scale |
| a_neg | output | 1 | Winding A polarity, 1 = negative |
| b_mag | output | 7 | Winding B magnitude, percent of full scale |
| b_neg | output | 1 | Winding B polarity, 1 = negative |
| home_n | output | 1 | 0 while at the home position |
| bridge_on | output | 1 | Registered bridge enable |

## Verification
The assertions check several rules on every cycle:
- the home flag agrees with the +71/+71 setpoint;
- park, sleep and fault requests drive the index home or hold it, and clear the bridge enable;
- the index never moves without a synchronised step event;
- eighth-forward and full-reverse steps move the index by the expected amount.

Only the bench scenarios can show the remaining behaviour:
- the full sine/cosine setpoint pattern around the cycle, and wrap-around in both directions;
- the exact three-edge latency, and one move per long pulse;
- that enable does not stop stepping, that mode changes do not realign the index, and that a pulse swallowed by sleep stays lost.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;
  localparam int IDX_W    = 5;
  localparam int N_POS    = 1 << IDX_W;
  localparam int QTR      = N_POS / 4;
  localparam int HALF     = N_POS / 2;
  localparam int HOME_IDX = N_POS / 8;
  localparam int N_WIND   = 2;
  localparam int PCT_W    = 7;

  typedef logic [IDX_W-1:0] idx_t;
  typedef enum logic [1:0] {MODE_FULL, MODE_HALF, MODE_QUARTER, MODE_EIGHTH} mode_e;

  // index increment for one accepted step edge
  function automatic idx_t stride_of(mode_e m);
    return idx_t'(QTR >> m);
  endfunction

  function automatic idx_t advance(idx_t p, logic fwd, mode_e m);
    return fwd ? idx_t'(p + stride_of(m)) : idx_t'(p - stride_of(m));
  endfunction

  // distance (in positions) from the nearest cosine peak, 0..QTR
  function automatic int fold(idx_t k);
    int j;
    j = int'(k) % HALF;
    return (j <= QTR) ? j : HALF - j;
  endfunction

  function automatic logic [PCT_W-1:0] level_pct(int d);
    case (d)
      0: return 7'd100;
      1: return 7'd98;
      2: return 7'd92;
      3: return 7'd83;
      4: return 7'd71;
      5: return 7'd56;
      6: return 7'd38;
      7: return 7'd20;
      default: return 7'd0;
    endcase
  endfunction

  // cosine negative strictly between 90 and 270 degrees
  function automatic logic cos_neg(idx_t k);
    return (int'(k) > QTR) && (int'(k) < 3 * QTR);
  endfunction
endpackage

// File: rtl/step_sync.sv
module step_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  output logic step_evt
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], step_in};
  end

  // sh[1] is the second synchroniser flop, sh[2] its delayed copy
  assign step_evt = sh[1] & ~sh[2];
endmodule

// File: rtl/idx_core.sv
module idx_core import stepidx_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       park_n,
  input  logic       fault_home,
  input  logic       sleep_n,
  input  logic       step_evt,
  input  logic       dir_fwd,
  input  logic [1:0] mode,
  output idx_t       pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pos <= idx_t'(HOME_IDX);
    else if (!park_n || fault_home) pos <= idx_t'(HOME_IDX);
    else if (sleep_n && step_evt)   pos <= advance(pos, dir_fwd, mode_e'(mode));
  end
endmodule

// File: rtl/phase_lut.sv
module phase_lut import stepidx_pkg::*; #(
  parameter int MAG_W  = 7,
  parameter int OFFSET = 0
) (
  input  idx_t             pos,
  output logic [MAG_W-1:0] mag,
  output logic             neg
);
  idx_t rel;

  always_comb begin
    rel = idx_t'(pos - idx_t'(OFFSET));
    mag = MAG_W'(level_pct(fold(rel)));
    neg = cos_neg(rel);
  end
endmodule

// File: rtl/stepidx_top.sv
module stepidx_top import stepidx_pkg::*; #(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             dir_fwd,
  input  logic [1:0]       mode,
  input  logic             park_n,
  input  logic             fault_home,
  input  logic             sleep_n,
  input  logic             enable,
  output logic [MAG_W-1:0] a_mag,
  output logic             a_neg,
  output logic [MAG_W-1:0] b_mag,
  output logic             b_neg,
  output logic             home_n,
  output logic             bridge_on
);
  logic             step_evt;
  idx_t             pos;
  logic [MAG_W-1:0] mags [N_WIND];
  logic             negs [N_WIND];

  step_sync u_sync (.clk(clk), .rst_n(rst_n), .step_in(step), .step_evt(step_evt));

  idx_core u_core (
    .clk(clk), .rst_n(rst_n), .park_n(park_n), .fault_home(fault_home),
    .sleep_n(sleep_n), .step_evt(step_evt), .dir_fwd(dir_fwd), .mode(mode),
    .pos(pos)
  );

  // winding w lags winding 0 by w quarter cycles (cos, then sin)
  for (genvar w = 0; w < N_WIND; w++) begin : g_wind
    phase_lut #(.MAG_W(MAG_W), .OFFSET(w * QTR)) u_lut (
      .pos(pos), .mag(mags[w]), .neg(negs[w])
    );
  end

  assign a_mag  = mags[0];
  assign a_neg  = negs[0];
  assign b_mag  = mags[1];
  assign b_neg  = negs[1];
  assign home_n = (pos != idx_t'(HOME_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bridge_on <= 1'b0;
    else        bridge_on <= park_n & enable & sleep_n;
  end
endmodule

// File: rtl/stepidx_chk.sv
module stepidx_chk import stepidx_pkg::*; #(
  parameter int MAG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_fwd,
  input logic [1:0]       mode,
  input logic             park_n,
  input logic             fault_home,
  input logic             sleep_n,
  input logic             enable,
  input logic             step_evt,
  input idx_t             pos,
  input logic [MAG_W-1:0] a_mag,
  input logic             a_neg,
  input logic [MAG_W-1:0] b_mag,
  input logic             b_neg,
  input logic             home_n,
  input logic             bridge_on
);
  assert_home_levels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !home_n |-> (a_mag == MAG_W'(71) && b_mag == MAG_W'(71) && !a_neg && !b_neg));

  assert_mag_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_mag <= MAG_W'(100) && b_mag <= MAG_W'(100));

  assert_zero_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_mag == '0) |-> !a_neg) and ((b_mag == '0) |-> !b_neg));

  assert_park_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !park_n |=> !home_n);

  assert_park_bridge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !park_n |=> !bridge_on);

  assert_enable_bridge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !bridge_on);

  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n && park_n && !fault_home) |=> $stable(pos));

  assert_sleep_bridge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !bridge_on);

  assert_fault_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_home |=> !home_n);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && park_n && !fault_home) |=> $stable(pos));

  assert_evt_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> !step_evt);

  assert_fine_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && park_n && sleep_n && !fault_home && dir_fwd && mode == 2'b11)
      |=> pos == idx_t'($past(pos) + idx_t'(1)));

  assert_full_rev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && park_n && sleep_n && !fault_home && !dir_fwd && mode == 2'b00)
      |=> pos == idx_t'($past(pos) - idx_t'(QTR)));

  assert_bridge_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (park_n && enable && sleep_n) |=> bridge_on);
endmodule

bind stepidx_top stepidx_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .mode(mode), .park_n(park_n),
  .fault_home(fault_home), .sleep_n(sleep_n), .enable(enable),
  .step_evt(step_evt), .pos(pos), .a_mag(a_mag), .a_neg(a_neg),
  .b_mag(b_mag), .b_neg(b_neg), .home_n(home_n), .bridge_on(bridge_on)
);

// File: tb/tb_stepidx_top.sv
module tb_stepidx_top;
  localparam int CLK_T = 10;
  localparam int NV    = 16;
  // {dir_fwd, mode, expected index after one step}, starting from home (4)
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 2'd3, 5'd5},  {1'b1, 2'd3, 5'd6},  {1'b1, 2'd2, 5'd8},  {1'b1, 2'd1, 5'd12},
    {1'b1, 2'd0, 5'd20}, {1'b1, 2'd0, 5'd28}, {1'b1, 2'd0, 5'd4},  {1'b0, 2'd3, 5'd3},
    {1'b0, 2'd2, 5'd1},  {1'b0, 2'd2, 5'd31}, {1'b0, 2'd0, 5'd23}, {1'b0, 2'd1, 5'd19},
    {1'b1, 2'd0, 5'd27}, {1'b1, 2'd1, 5'd31}, {1'b1, 2'd3, 5'd0},  {1'b0, 2'd3, 5'd31}
  };

  logic clk = 0, rst_n = 0, step = 0, dir_fwd = 1;
  logic [1:0] mode = 2'd3;
  logic park_n = 1, fault_home = 0, sleep_n = 1, enable = 1;
  logic [6:0] a_mag, b_mag;
  logic a_neg, b_neg, home_n, bridge_on;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  stepidx_top dut (
    .clk(clk), .rst_n(rst_n), .step(step), .dir_fwd(dir_fwd), .mode(mode),
    .park_n(park_n), .fault_home(fault_home), .sleep_n(sleep_n), .enable(enable),
    .a_mag(a_mag), .a_neg(a_neg), .b_mag(b_mag), .b_neg(b_neg),
    .home_n(home_n), .bridge_on(bridge_on)
  );

  function automatic int pct(int d);
    int t [9] = '{100, 98, 92, 83, 71, 56, 38, 20, 0};
    return t[d];
  endfunction

  // {neg, mag} by quadrant: winding A = cos, winding B = sin
  function automatic int exp_a(int k);
    int q = k / 8, r = k % 8;
    case (q)
      0: return pct(r);
      1: return (r == 0) ? 0 : 128 + pct(8 - r);
      2: return 128 + pct(r);
      default: return pct(8 - r);
    endcase
  endfunction

  function automatic int exp_b(int k);
    int q = k / 8, r = k % 8;
    case (q)
      0: return pct(8 - r);
      1: return pct(r);
      2: return (r == 0) ? 0 : 128 + pct(8 - r);
      default: return 128 + pct(r);
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(input string req, input int k);
    chk({req, " winding A"}, {24'd0, a_neg, a_mag}, exp_a(k));
    chk({req, " winding B"}, {24'd0, b_neg, b_mag}, exp_b(k));
    chk({req, " home flag R5"}, int'(home_n), (k == 4) ? 0 : 1);
  endtask

  task automatic pulse_step();
    step = 1;
    repeat (4) @(negedge clk);
    step = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 bridge off in reset", int'(bridge_on), 0);
    rst_n = 1;
    @(negedge clk);
    chk_pos("R4 reset home", 4);
    chk("R12 bridge on", int'(bridge_on), 1);

    // vector walk: R1 R2 R3 R5 R11
    for (int i = 0; i < NV; i++) begin
      dir_fwd = VEC[i][7];
      mode    = VEC[i][6:5];
      pulse_step();
      chk_pos($sformatf("R1 R2 R3 R11 vector %0d", i), int'(VEC[i][4:0]));
    end
    // now at 31

    // R10 latency and single move per long pulse
    dir_fwd = 1; mode = 2'd3;
    step = 1;
    @(negedge clk); @(negedge clk);
    chk_pos("R10 no move after two edges", 31);
    @(negedge clk);
    chk_pos("R10 move on third edge", 0);
    repeat (10) @(negedge clk);
    step = 0;
    repeat (4) @(negedge clk);
    chk_pos("R10 one move per long pulse", 0);

    // R7 enable low still steps
    enable = 0;
    pulse_step();
    chk_pos("R7 step while disabled", 1);
    chk("R7 bridge off", int'(bridge_on), 0);
    enable = 1;

    // R6 park
    park_n = 0;
    @(negedge clk);
    chk_pos("R6 park forces home", 4);
    chk("R6 bridge off", int'(bridge_on), 0);
    pulse_step();
    chk_pos("R6 step ignored in park", 4);
    park_n = 1;
    @(negedge clk);
    pulse_step();
    chk_pos("R6 step after park", 5);

    // R8 sleep
    sleep_n = 0;
    @(negedge clk);
    chk("R8 bridge off", int'(bridge_on), 0);
    pulse_step();
    chk_pos("R8 step ignored in sleep", 5);
    sleep_n = 1;
    repeat (4) @(negedge clk);
    chk_pos("R8 no late move after wake", 5);
    chk("R12 bridge back on", int'(bridge_on), 1);

    // R9 fault return-home pulse
    mode = 2'd0;
    pulse_step();
    chk_pos("R11 full step from odd index", 13);
    fault_home = 1;
    @(negedge clk);
    fault_home = 0;
    chk_pos("R9 fault forces home", 4);
    @(negedge clk);
    chk_pos("R9 home held after pulse", 4);

    // R2 reverse wrap in half mode from home
    dir_fwd = 0; mode = 2'd1;
    pulse_step();
    chk_pos("R2 reverse wrap", 0);
    pulse_step();
    chk_pos("R2 reverse wrap below zero", 28);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule